// File: doc/BRIEF.md
# Transmit Enable Delay Controller

This block sits between an asynchronous transmit-enable pin and the sample datapath of a converter. It runs on the converter clock and divides that clock by 64 to make a slow tick. When the enable pin goes high, the block waits before it raises a qualified output-valid strobe. The wait has two parts. First comes a selectable number of divided ticks. Then comes a fixed run of fast-clock cycles. The wait is abandoned at once if the pin falls first, and output-valid drops one clock after the synchronized pin goes low.

While the pin is low, the block also drives five power-down requests. Each request has its own configuration bit that allows it. Both the delay selects and the power-down selects are static configuration inputs.

Top module: `txen_delay_ctrl`

## Requirements
- R1: While `rst_n` is low, `out_valid_o` is 0 and `pd_o` is all zeros.
- R2: Edge 1 is the first rising clock edge with `rst_n` high. The divided tick is sampled at edges 64, 128, 192 and so on. Suppose `txen_i` rises before edge a and stays high. The rise is detected at edge a+2. With `ext_dly_en_i`=0, `out_valid_o` goes high right after edge m+10, where m is the first tick edge later than a+2. In this mode `ext_dly_long_i` has no effect.
- R3: With `ext_dly_en_i`=1 and `ext_dly_long_i`=0, m is the 12th tick edge later than a+2. `out_valid_o` rises after edge m+10.
- R4: With `ext_dly_en_i`=1 and `ext_dly_long_i`=1, m is the 19th tick edge later than a+2. `out_valid_o` rises after edge m+10.
- R5: If `txen_i` falls before `out_valid_o` has risen, `out_valid_o` stays low. This holds whether the fall comes during the tick count or during the fixed 10-cycle window. The next rise starts the whole delay again from zero.
- R6: Suppose `txen_i` falls before edge b. `out_valid_o` is still high after edge b+1 and is low after edge b+2.
- R7: `pd_o[i]` is 1 exactly when `pd_sel_i[i]` is 1 and the synchronized enable is low. After `txen_i` changes before edge a, `pd_o` takes its new value after edge a+2. The bits are: [4] reference, [3] PLL, [2] converter cores, [1] FIFO, [0] interpolation filters.
- R8: A tick that falls on the detection edge a+2 itself is not counted. The count starts with the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, deasserts in step with `clk` |
| txen_i | input | 1 | Asynchronous transmit-enable pin |
| ext_dly_en_i | input | 1 | Static select: 1 uses the extended tick count |
| ext_dly_long_i | input | 1 | Static select: with the extended count chosen, 1 picks the longer count |
| pd_sel_i | input | 5 | Static per-function power-down allow bits |
| out_valid_o | output | 1 | Qualified output-enable for the datapath |
| pd_o | output | 5 | Per-function power-down requests |

## Verification
The embedded properties assume three things about the inputs. The delay selects do not change while a delay is running. Reset is released on a clock-aligned instant. The enable pin holds each level for at least the two synchronizer cycles.

The stimulus keeps inside these limits. It changes the selects only while the enable pin has been low for several cycles. It releases reset and drives every input on the falling clock edge. It never toggles the pin faster than the synchronizer can follow.

Launch phases are picked relative to the divided tick. They cover the case where a tick lands on the detection edge, the case where it lands on the edge just after, and the case where it lands just before.

// File: rtl/txen_pkg.sv
package txen_pkg;

  localparam int PD_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FIXED = 2'd2,
    ST_ON    = 2'd3
  } dly_state_e;

endpackage

// File: rtl/txen_sync.sv
module txen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/txen_tick_gen.sv
module txen_tick_gen #(
  parameter int DIV_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = &cnt_q;

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/txen_delay_fsm.sv
module txen_delay_fsm
  import txen_pkg::*;
#(
  parameter int FIXED_CYC   = 10,
  parameter int SHORT_TICKS = 1,
  parameter int MID_TICKS   = 12,
  parameter int LONG_TICKS  = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s_i,
  input  logic tick_i,
  input  logic ext_en_i,
  input  logic ext_long_i,
  output logic valid_o
);

  localparam int TCNT_W = $clog2(LONG_TICKS + 1);
  localparam int FCNT_W = $clog2(FIXED_CYC + 1);
  localparam logic [FCNT_W-1:0] FIXED_LAST = FCNT_W'(FIXED_CYC - 1);

  dly_state_e        st_q, st_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d, target;
  logic [FCNT_W-1:0] fcnt_q, fcnt_d;
  logic              tcnt_en, fcnt_en;

  always_comb begin
    if (ext_en_i) target = ext_long_i ? TCNT_W'(LONG_TICKS) : TCNT_W'(MID_TICKS);
    else          target = TCNT_W'(SHORT_TICKS);
  end

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    fcnt_d = fcnt_q;
    case (st_q)
      ST_IDLE: begin
        if (en_s_i) begin
          st_d   = ST_WAIT;
          tcnt_d = '0;
        end
      end
      ST_WAIT: begin
        if (tick_i) begin
          if (tcnt_q == target - 1'b1) begin
            st_d   = ST_FIXED;
            fcnt_d = '0;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_FIXED: begin
        if (fcnt_q == FIXED_LAST) st_d   = ST_ON;
        else                      fcnt_d = fcnt_q + 1'b1;
      end
      default: st_d = ST_ON;
    endcase
    if (!en_s_i) begin
      st_d   = ST_IDLE;
      tcnt_d = '0;
      fcnt_d = '0;
    end
  end

  assign tcnt_en = (tcnt_d != tcnt_q);
  assign fcnt_en = (fcnt_d != fcnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tcnt_q <= '0;
    else if (tcnt_en) tcnt_q <= tcnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fcnt_q <= '0;
    else if (fcnt_en) fcnt_q <= fcnt_d;
  end

  assign valid_o = (st_q == ST_ON);

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s_i |=> !valid_o);

  // R5
  valid_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> (en_s_i && $past(en_s_i)));

  // R3
  tcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> (tcnt_q < target));

  // R2
  fcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIXED) |-> (fcnt_q <= FIXED_LAST));

endmodule

// File: rtl/txen_pwrdn.sv
module txen_pwrdn #(
  parameter int PD_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_s_i,
  input  logic [PD_W-1:0] sel_i,
  output logic [PD_W-1:0] pd_o
);

  logic [PD_W-1:0] pd_q, pd_d;

  for (genvar g = 0; g < PD_W; g++) begin : g_bit
    always_comb pd_d[g] = sel_i[g] & ~en_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= '0;
    else        pd_q <= pd_d;
  end

  assign pd_o = pd_q;

  // R7
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s_i && $past(en_s_i)) |-> (pd_o == '0));

endmodule

// File: rtl/txen_delay_ctrl.sv
module txen_delay_ctrl
  import txen_pkg::*;
#(
  parameter int DIV_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int FIXED_CYC   = 10,
  parameter int SHORT_TICKS = 1,
  parameter int MID_TICKS   = 12,
  parameter int LONG_TICKS  = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            txen_i,
  input  logic            ext_dly_en_i,
  input  logic            ext_dly_long_i,
  input  logic [PD_W-1:0] pd_sel_i,
  output logic            out_valid_o,
  output logic [PD_W-1:0] pd_o
);

  logic en_s;
  logic tick;

  txen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (txen_i),
    .q_o   (en_s)
  );

  txen_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  txen_delay_fsm #(
    .FIXED_CYC   (FIXED_CYC),
    .SHORT_TICKS (SHORT_TICKS),
    .MID_TICKS   (MID_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_s_i     (en_s),
    .tick_i     (tick),
    .ext_en_i   (ext_dly_en_i),
    .ext_long_i (ext_dly_long_i),
    .valid_o    (out_valid_o)
  );

  txen_pwrdn #(.PD_W(PD_W)) u_pd (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_s_i (en_s),
    .sel_i  (pd_sel_i),
    .pd_o   (pd_o)
  );

endmodule

// File: tb/sim_txen_delay_ctrl.sv
`timescale 1ns/1ps
module sim_txen_delay_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       txen;
  logic       ext_en;
  logic       ext_long;
  logic [4:0] pd_sel;
  logic       valid;
  logic [4:0] pd;

  int unsigned ecount;
  int          nvec  = 0;
  int          nfail = 0;
  bit          done  = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  txen_delay_ctrl u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .txen_i         (txen),
    .ext_dly_en_i   (ext_en),
    .ext_dly_long_i (ext_long),
    .pd_sel_i       (pd_sel),
    .out_valid_o    (valid),
    .pd_o           (pd)
  );

  // {ext_en, ext_long, phase of detection edge modulo 64}
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    {1'b0, 1'b0, 6'd0},   // R8 tick on detection edge
    {1'b0, 1'b0, 6'd1},
    {1'b0, 1'b0, 6'd63},
    {1'b0, 1'b1, 6'd5},   // R2 long select ignored
    {1'b1, 1'b0, 6'd0},
    {1'b1, 1'b0, 6'd40},
    {1'b1, 1'b1, 6'd0},
    {1'b1, 1'b1, 6'd17}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nticks(input bit e, input bit l);
    return e ? (l ? 19 : 12) : 1;
  endfunction

  function automatic int exp_edge(input int a, input int n);
    int det = a + 2;
    int m1  = (det / 64 + 1) * 64;
    return m1 + 64 * (n - 1) + 10;
  endfunction

  task automatic align(input int phase);
    while (((ecount + 3) % 64) != phase) @(negedge clk);
  endtask

  task automatic run_delay(input bit e, input bit l, input int phase, input string req);
    int a, ex, first, b;
    ext_en = e; ext_long = l;
    repeat (4) @(negedge clk);
    align(phase);
    txen = 1'b1;
    a  = int'(ecount) + 1;
    ex = exp_edge(a, nticks(e, l));
    first = 0;
    while (int'(ecount) < ex + 2) begin
      @(negedge clk);
      if (valid && first == 0) first = int'(ecount);
    end
    check(first == ex, req, first, ex);
    txen = 1'b0;
    b = int'(ecount) + 1;
    @(negedge clk); @(negedge clk);
    check(valid == 1'b1, "R6 held after b+1", int'(valid), 1);
    @(negedge clk);
    check(valid == 1'b0, "R6 low after b+2", int'(valid), 0);
    if (b < 0) $display("unreachable");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int a, ex, mn;
    bit seen;
    rst_n = 1'b0; txen = 1'b0; ext_en = 1'b0; ext_long = 1'b0; pd_sel = 5'h1F;
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
    check(pd == 5'h00, "R1 pd in reset", int'(pd), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pd == 5'h1F, "R7 pd all allowed, pin low", int'(pd), 31);
    pd_sel = 5'h00;

    for (int i = 0; i < NV; i++)
      run_delay(VEC[i][7], VEC[i][6], int'(VEC[i][5:0]),
                VEC[i][7] ? (VEC[i][6] ? "R4 long delay" : "R3 mid delay")
                          : "R2 short delay");

    // R7 power-down gating with a mixed select pattern
    pd_sel = 5'b10110;
    repeat (4) @(negedge clk);
    check(pd == 5'b10110, "R7 pd while low", int'(pd), 22);
    txen = 1'b1;
    @(negedge clk); @(negedge clk);
    check(pd == 5'b10110, "R7 pd still set after a+1", int'(pd), 22);
    @(negedge clk);
    check(pd == 5'b00000, "R7 pd cleared after a+2", int'(pd), 0);
    txen = 1'b0;
    @(negedge clk); @(negedge clk);
    check(pd == 5'b00000, "R7 pd still clear after b+1", int'(pd), 0);
    @(negedge clk);
    check(pd == 5'b10110, "R7 pd back after b+2", int'(pd), 22);
    pd_sel = 5'b01001;
    repeat (2) @(negedge clk);
    check(pd == 5'b01001, "R7 pd follows select", int'(pd), 9);
    pd_sel = 5'h00;
    repeat (4) @(negedge clk);

    // R5 cancel during tick counting
    ext_en = 1'b1; ext_long = 1'b1;
    repeat (4) @(negedge clk);
    txen = 1'b1;
    a  = int'(ecount) + 1;
    ex = exp_edge(a, 19);
    repeat (300) @(negedge clk);
    txen = 1'b0;
    seen = 1'b0;
    while (int'(ecount) < ex + 20) begin
      @(negedge clk);
      if (valid) seen = 1'b1;
    end
    check(!seen, "R5 cancel during count", int'(seen), 0);
    run_delay(1'b1, 1'b0, 9, "R5 restart after cancel");

    // R5 cancel inside the fixed window
    ext_en = 1'b0; ext_long = 1'b0;
    repeat (4) @(negedge clk);
    align(20);
    txen = 1'b1;
    a  = int'(ecount) + 1;
    ex = exp_edge(a, 1);
    mn = ex - 10;
    while (int'(ecount) < mn + 3) @(negedge clk);
    txen = 1'b0;
    seen = 1'b0;
    while (int'(ecount) < ex + 20) begin
      @(negedge clk);
      if (valid) seen = 1'b1;
    end
    check(!seen, "R5 cancel in fixed window", int'(seen), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule